// File: doc/BRIEF.md
# Floating-Point Rounding Stage

This block sits between an add/subtract datapath and a later exceptions stage in a double-precision arithmetic pipe. The datapath hands it three things: a sign, a 12-bit exponent and a 56-bit extended mantissa. The mantissa carries a zero pad above the hidden one and two remainder bits below the fraction. The block also takes a 2-bit rounding direction. It decides whether the kept fraction must grow by one unit in the last place. If so, it adds that unit and renormalizes when the addition carries past the hidden bit. It then packs sign, exponent and fraction into a 64-bit word.

The exponent is kept 12 bits wide through the whole stage. Because of this, an exponent that runs past 2047, whether on entry or from the renormalizing carry, is reported on a separate flag and is not lost through wrap-around. Infinity saturation, NaN handling and exception flags belong to the stage that follows. The packed word and flag are registered, so results appear one clock after the inputs are presented.

Top module: `fpr_round_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs go to zero: `word_o` = 0 and `exp_ovf_o` = 0.
- R2: `word_o` and `exp_ovf_o` reflect the inputs sampled at the previous rising edge of `clk`, a latency of exactly one cycle.
- R3: Mode code 0 (nearest, ties to even) adds one unit at mantissa bit 2 when bit 1 is set and at least one of bit 0 or bit 2 is set.
- R4: Mode code 1 (toward zero) never adds; the output fraction and exponent equal the truncated input fields.
- R5: Mode code 2 (toward plus infinity) adds one unit only when the sign is 0 and bit 1 or bit 0 is set.
- R6: Mode code 3 (toward minus infinity) adds one unit only when the sign is 1 and bit 1 or bit 0 is set.
- R7: The mantissa term's bits 1:0 never reach the output. The word's bits 51:0 are mantissa bits 53:2 after rounding, so the output fraction equals either the input fraction or the input fraction plus one, taken modulo 2^52.
- R8: When the addition carries into mantissa bit 55, the mantissa is shifted right by one and the exponent is incremented. The output fraction is then zero.
- R9: The output word packs sign in bit 63, exponent bits 10:0 in bits 62:52 and the fraction in bits 51:0. Exponent bit 11 after rounding is driven on `exp_ovf_o`.
- R10: The sign input passes to bit 63 unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rmode_i | input | 2 | Rounding direction: 0 nearest-even, 1 toward zero, 2 up, 3 down |
| sign_i | input | 1 | Sign of the unrounded result |
| exp_i | input | 12 | Biased exponent with extra overflow MSB |
| man_i | input | 56 | Zero pad (55), hidden one (54), fraction (53:2), remainder (1:0) |
| word_o | output | 64 | Packed double-precision result |
| exp_ovf_o | output | 1 | Bit 11 of the rounded exponent |

## Verification
A wrong rounding decision appears at the port one cycle later as a fraction that is off by exactly one in its last bit. Only the inputs whose remainder bits, sign and mode meet a decision boundary reveal it, so ties, sticky-only remainders and each sign in each directed mode are exercised. A lost renormalizing carry shows at the same point as a cleared fraction that comes with an exponent that did not move, or as a missing overflow flag when the exponent was already at 2047. No state persists across operations, so every fault is visible within the single cycle after the offending input.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    localparam int MAN_W  = 56;
    localparam int EXP_W  = 12;
    localparam int REM_W  = 2;
    localparam int FRAC_W = MAN_W - REM_W - 2;
    localparam int WORD_W = 1 + (EXP_W - 1) + FRAC_W;
    localparam int ULP_POS = REM_W;
    localparam int PAD_POS = MAN_W - 1;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TO_ZERO   = 2'd1,
        RM_UP        = 2'd2,
        RM_DOWN      = 2'd3
    } rmode_e;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] expo;
        logic [MAN_W-1:0] man;
    } term_t;

    // Decide whether one unit in the last place must be added.
    function automatic logic need_bump(rmode_e m, logic s, logic lsb,
                                       logic half, logic sticky);
        logic any_rem;
        any_rem = half | sticky;
        case (m)
            RM_NEAR_EVEN: need_bump = half & (sticky | lsb);
            RM_TO_ZERO:   need_bump = 1'b0;
            RM_UP:        need_bump = any_rem & ~s;
            RM_DOWN:      need_bump = any_rem & s;
            default:      need_bump = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
    import fpr_pkg::*;
(
    input  rmode_e           mode,
    input  logic             sign,
    input  logic [MAN_W-1:0] man,
    output logic             bump
);
    logic lsb, half, sticky;

    always_comb begin
        lsb    = man[ULP_POS];
        half   = man[ULP_POS-1];
        sticky = |man[ULP_POS-2:0];
        bump   = need_bump(mode, sign, lsb, half, sticky);
    end

endmodule

// File: rtl/fpr_incr.sv
module fpr_incr
    import fpr_pkg::*;
(
    input  term_t in_t,
    input  logic  bump,
    output term_t out_t
);
    localparam logic [MAN_W-1:0] ULP_K = MAN_W'(1) << ULP_POS;

    logic [MAN_W-1:0] sum;
    logic             carry;

    always_comb begin
        sum   = in_t.man + (bump ? ULP_K : '0);
        carry = sum[PAD_POS];
        out_t.sign = in_t.sign;
        out_t.man  = carry ? (sum >> 1) : sum;
        out_t.expo = in_t.expo + EXP_W'(carry);
    end

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
    import fpr_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  term_t             res_t,
    output logic [WORD_W-1:0] word,
    output logic              ovf
);
    logic [WORD_W-1:0] word_c;
    logic              ovf_c;
    logic [2:0]        unused_bits;

    always_comb begin
        word_c = {res_t.sign, res_t.expo[EXP_W-2:0],
                  res_t.man[FRAC_W+ULP_POS-1:ULP_POS]};
        ovf_c  = res_t.expo[EXP_W-1];
    end

    assign unused_bits = {res_t.man[PAD_POS], res_t.man[PAD_POS-1], ^res_t.man[ULP_POS-1:0]};

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    word <= '0;
                    ovf  <= 1'b0;
                end else begin
                    word <= word_c;
                    ovf  <= ovf_c;
                end
            end
        end else begin : g_comb
            always_comb begin
                word = word_c;
                ovf  = ovf_c;
            end
        end
    endgenerate

endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
    import fpr_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        rmode_i,
    input  logic              sign_i,
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [MAN_W-1:0]  man_i,
    output logic [WORD_W-1:0] word_o,
    output logic              exp_ovf_o
);
    term_t  raw_t, rnd_t;
    logic   bump;
    rmode_e mode;

    always_comb begin
        mode       = rmode_e'(rmode_i);
        raw_t.sign = sign_i;
        raw_t.expo = exp_i;
        raw_t.man  = man_i;
    end

    fpr_decide u_decide (
        .mode (mode),
        .sign (sign_i),
        .man  (man_i),
        .bump (bump)
    );

    fpr_incr u_incr (
        .in_t  (raw_t),
        .bump  (bump),
        .out_t (rnd_t)
    );

    fpr_pack #(.OUT_REG(OUT_REG)) u_pack (
        .clk   (clk),
        .rst   (rst),
        .res_t (rnd_t),
        .word  (word_o),
        .ovf   (exp_ovf_o)
    );

    generate
        if (OUT_REG) begin : g_chk
            logic primed;
            always_ff @(posedge clk) begin
                if (rst) primed <= 1'b0;
                else     primed <= 1'b1;
            end

            // R10: sign travels unchanged
            a_r10_sign_passes: assert property (@(posedge clk) disable iff (rst)
                primed |-> word_o[WORD_W-1] == $past(sign_i));

            // R4: toward-zero leaves fields truncated
            a_r4_rtz_truncates: assert property (@(posedge clk) disable iff (rst)
                (primed && $past(rmode_i) == 2'd1) |->
                (word_o[FRAC_W-1:0] == $past(man_i[FRAC_W+ULP_POS-1:ULP_POS])
                 && word_o[WORD_W-2:FRAC_W] == $past(exp_i[EXP_W-2:0])));

            // R7: fraction moves by at most one unit
            a_r7_frac_step: assert property (@(posedge clk) disable iff (rst)
                primed |->
                (word_o[FRAC_W-1:0] == $past(man_i[FRAC_W+ULP_POS-1:ULP_POS])
                 || word_o[FRAC_W-1:0] == $past(man_i[FRAC_W+ULP_POS-1:ULP_POS]) + FRAC_W'(1)));

            // R8: an exponent bump only comes with a cleared fraction
            a_r8_carry_bump: assert property (@(posedge clk) disable iff (rst)
                (primed && word_o[WORD_W-2:FRAC_W] != $past(exp_i[EXP_W-2:0])) |->
                word_o[FRAC_W-1:0] == '0);

            // R9: overflow flag only from a saturated or overflowed exponent
            a_r9_ovf_source: assert property (@(posedge clk) disable iff (rst)
                (primed && exp_ovf_o) |->
                ($past(exp_i[EXP_W-1]) || $past(exp_i[EXP_W-2:0]) == '1));
        end
    endgenerate

endmodule

// File: tb/fpr_round_unit_tb.sv
module fpr_round_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  rmode_i = '0;
    logic        sign_i = 1'b0;
    logic [11:0] exp_i = '0;
    logic [55:0] man_i = '0;
    logic [63:0] word_o;
    logic        exp_ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fpr_round_unit u_dut (
        .clk(clk), .rst(rst), .rmode_i(rmode_i), .sign_i(sign_i),
        .exp_i(exp_i), .man_i(man_i), .word_o(word_o), .exp_ovf_o(exp_ovf_o)
    );

    localparam logic [51:0] ONES = '1;

    // mode, sign, exp, fraction, remainder, expected word, expected flag
    localparam logic [133:0] VEC [15] = '{
        {2'd0, 1'b0, 12'h3FF, 52'h0,  2'b10, 64'h3FF0000000000000, 1'b0},
        {2'd0, 1'b0, 12'h3FF, 52'h1,  2'b10, 64'h3FF0000000000002, 1'b0},
        {2'd0, 1'b0, 12'h3FF, 52'h0,  2'b11, 64'h3FF0000000000001, 1'b0},
        {2'd0, 1'b0, 12'h3FF, 52'h1,  2'b01, 64'h3FF0000000000001, 1'b0},
        {2'd1, 1'b0, 12'h3FF, 52'h5,  2'b11, 64'h3FF0000000000005, 1'b0},
        {2'd2, 1'b0, 12'h3FF, 52'h0,  2'b01, 64'h3FF0000000000001, 1'b0},
        {2'd2, 1'b1, 12'h3FF, 52'h0,  2'b11, 64'hBFF0000000000000, 1'b0},
        {2'd3, 1'b1, 12'h3FF, 52'h0,  2'b10, 64'hBFF0000000000001, 1'b0},
        {2'd3, 1'b0, 12'h3FF, 52'h3,  2'b11, 64'h3FF0000000000003, 1'b0},
        {2'd2, 1'b0, 12'h3FF, 52'h7,  2'b00, 64'h3FF0000000000007, 1'b0},
        {2'd0, 1'b0, 12'h3FF, ONES,   2'b11, 64'h4000000000000000, 1'b0},
        {2'd2, 1'b0, 12'h7FE, ONES,   2'b01, 64'h7FF0000000000000, 1'b0},
        {2'd3, 1'b1, 12'h7FF, ONES,   2'b10, 64'h8000000000000000, 1'b1},
        {2'd1, 1'b0, 12'h800, 52'h0,  2'b00, 64'h0000000000000000, 1'b1},
        {2'd0, 1'b1, 12'h3FF, ONES,   2'b10, 64'hC000000000000000, 1'b0}
    };
    localparam string TAG [15] = '{"R3","R3","R3","R3","R4","R5","R5","R6",
                                   "R6","R5","R8","R8","R9","R9","R3"};

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(logic [1:0] m, logic s, logic [11:0] e,
                         logic [51:0] f, logic [1:0] r);
        rmode_i = m; sign_i = s; exp_i = e; man_i = {2'b01, f, r};
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset clears outputs even with busy inputs
        drive(2'd2, 1'b1, 12'hFFF, ONES, 2'b11);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 word", word_o, 64'h0);
        chk("R1 flag", {63'h0, exp_ovf_o}, 64'h0);
        @(negedge clk); rst = 1'b0;

        // table walk (R3..R9, R7 throughout)
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            drive(VEC[i][133:132], VEC[i][131], VEC[i][130:119],
                  VEC[i][118:67], VEC[i][66:65]);
            @(posedge clk); #1;
            chk(TAG[i], word_o, VEC[i][64:1]);
            chk({TAG[i], " flag"}, {63'h0, exp_ovf_o}, {63'h0, VEC[i][0]});
        end

        // R2: output holds until the next edge, then updates
        @(negedge clk);
        drive(2'd1, 1'b0, 12'h123, 52'hABC, 2'b11);
        @(posedge clk); #1;
        chk("R2 first", word_o, 64'h1230000000000ABC);
        @(negedge clk);
        drive(2'd1, 1'b1, 12'h456, 52'hDEF, 2'b00);
        #1;
        chk("R2 hold", word_o, 64'h1230000000000ABC);
        @(posedge clk); #1;
        chk("R2 update", word_o, 64'hC560000000000DEF);

        // R10 / R7: remainder bits only matter through rounding
        @(negedge clk);
        drive(2'd1, 1'b1, 12'h001, 52'h0, 2'b11);
        @(posedge clk); #1;
        chk("R7 R10", word_o, 64'h8010000000000000);

        // R1 again mid-run
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        chk("R1 mid", word_o, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule